// File: doc/BRIEF.md
# Drive Ready and Retract Sequencer

This block decides when a disk drive may leave its retracted, safe state and when it is ready. After power-on the carriage return signal is held in its retract state. Once the spindle reports rotation in the correct direction and up-to-speed, each once-per-revolution fixed index strobe moves a chain of ready-delay stages forward. The first stage lets the carriage out of retract. After the last delay stage, one more index strobe produces a single load-head pulse and raises ready.

Five conditions force a retract and return the sequence to its start: a return-zero command, a retract request, an AC or DC power loss, a spindle speed-loss fault, and the run/load switch set to load. A power loss also starts a recovery timer. The retract is held until that timer expires. A loss that recurs while the timer runs starts it again. When the timer expires the sequence re-arms by itself on the following index strobes, provided the other inputs still allow it.

Top module: `drive_ready_seq`

## Requirements
- R1: While rst_ni is low, and on the first cycle after it rises, rtz_no is 1, ready_o is 0 and load_head_o is 0.
- R2: A clock edge that samples index_i=1 with spin_ok_i=1, up_to_speed_i=1 and no retract condition sets the first stage, and rtz_no is 0 after that edge.
- R3: With DELAY_STAGES=2, the third qualifying index strobe counted from the one that armed the chain makes load_head_o 1 for exactly one cycle, and ready_o becomes 1 after the same edge.
- R4: While ready_o is 1, further index strobes produce no load-head pulse, and ready_o stays 1.
- R5: Any one of rtz_cmd_i=1, retract_req_i=1, pwr_loss_i=1, speed_loss_i=1 or run_i=0 (0 selects load) sampled on an edge makes rtz_no 1 and ready_o 0 after that edge.
- R6: After a retract, the chain restarts from its first stage. Ready needs DELAY_STAGES+1 new qualifying index strobes.
- R7: A power loss whose last sampled cycle is at edge e holds the retract through edge e+LOSS_CYCLES. An index strobe at e+LOSS_CYCLES is ignored, and one at e+LOSS_CYCLES+1 re-arms the chain with no other input. A loss seen while the timer runs starts the full window again.
- R8: A retract condition sampled on the same edge as an index strobe wins: the stage does not set.
- R9: An index strobe sampled while spin_ok_i=0 or up_to_speed_i=0 leaves rtz_no at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| index_i | input | 1 | Fixed index strobe, one cycle per revolution |
| spin_ok_i | input | 1 | Spindle rotating in the correct direction |
| up_to_speed_i | input | 1 | Spindle at speed |
| run_i | input | 1 | Switch position: 1 run, 0 load |
| rtz_cmd_i | input | 1 | Return-zero command |
| retract_req_i | input | 1 | Retract request |
| pwr_loss_i | input | 1 | AC or DC power loss |
| speed_loss_i | input | 1 | Excessive spindle speed loss |
| rtz_no | output | 1 | Carriage return, active low (1 = retract) |
| load_head_o | output | 1 | One-cycle load-head pulse |
| ready_o | output | 1 | Drive ready |

## Verification
The bench checks the exact edges of the recovery window. An index strobe on the last busy edge must be ignored, and one on the next edge must arm the chain. An off-by-one timer would accept the first or reject the second. A second loss during the window must restart the count; a timer that keeps running would re-arm too early. The bench drives an index strobe on the same edge as a fault or a switch change, which catches a design that gives the set priority over the clear. After an abort it counts the index strobes needed again, which catches a chain that keeps its later stages. It also repeats index strobes while the drive is ready, which catches a load-head pulse that fires more than once.

// File: rtl/drv_seq_pkg.sv
package drv_seq_pkg;
  typedef struct packed {
    logic cmd;
    logic retract;
    logic pwr_loss;
    logic speed_loss;
    logic load_sel;
  } abort_src_t;

  function automatic logic any_abort(abort_src_t s);
    return s.cmd | s.retract | s.pwr_loss | s.speed_loss | s.load_sel;
  endfunction
endpackage

// File: rtl/drv_loss_timer.sv
module drv_loss_timer #(
  parameter int unsigned LOSS_CYCLES = 250000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic loss_i,
  output logic busy_o
);
  localparam int unsigned CW = $clog2(LOSS_CYCLES + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (loss_i)        cnt_q <= CW'(LOSS_CYCLES);  // a repeat loss reloads
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/drv_abort_merge.sv
module drv_abort_merge
  import drv_seq_pkg::*;
(
  input  abort_src_t src_i,
  input  logic       loss_busy_i,
  input  logic       spin_ok_i,
  input  logic       up_to_speed_i,
  output logic       abort_o,
  output logic       start_ok_o
);
  always_comb begin
    abort_o    = any_abort(src_i) | loss_busy_i;
    start_ok_o = spin_ok_i & up_to_speed_i & ~abort_o;
  end
endmodule

// File: rtl/drv_ready_chain.sv
module drv_ready_chain #(
  parameter int unsigned DELAY_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic index_i,
  input  logic start_ok_i,
  input  logic abort_i,
  output logic armed_o,
  output logic ready_o,
  output logic load_head_o
);
  localparam int unsigned LAST = DELAY_STAGES - 1;

  logic [DELAY_STAGES-1:0] stage_q;
  logic ready_q, lh_q, fire;

  for (genvar k = 0; k < DELAY_STAGES; k++) begin : g_stage
    logic set_k;
    if (k == 0) begin : g_first
      assign set_k = index_i & start_ok_i;
    end else begin : g_next
      assign set_k = index_i & stage_q[k-1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      stage_q[k] <= 1'b0;
      else if (abort_i) stage_q[k] <= 1'b0;  // clear wins over set
      else if (set_k)   stage_q[k] <= 1'b1;
    end
  end

  assign fire = index_i & stage_q[LAST] & ~ready_q & ~abort_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ready_q <= 1'b0;
      lh_q    <= 1'b0;
    end else begin
      lh_q <= fire;
      if (abort_i)   ready_q <= 1'b0;
      else if (fire) ready_q <= 1'b1;
    end
  end

  assign armed_o     = stage_q[0];
  assign ready_o     = ready_q;
  assign load_head_o = lh_q;
endmodule

// File: rtl/drive_ready_seq.sv
module drive_ready_seq
  import drv_seq_pkg::*;
#(
  parameter int unsigned DELAY_STAGES = 2,
  parameter int unsigned LOSS_CYCLES  = 250000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic index_i,
  input  logic spin_ok_i,
  input  logic up_to_speed_i,
  input  logic run_i,
  input  logic rtz_cmd_i,
  input  logic retract_req_i,
  input  logic pwr_loss_i,
  input  logic speed_loss_i,
  output logic rtz_no,
  output logic load_head_o,
  output logic ready_o
);
  abort_src_t src;
  logic loss_busy, abort, start_ok, armed;

  assign src = '{cmd: rtz_cmd_i, retract: retract_req_i, pwr_loss: pwr_loss_i,
                 speed_loss: speed_loss_i, load_sel: ~run_i};

  drv_loss_timer #(.LOSS_CYCLES(LOSS_CYCLES)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .loss_i (pwr_loss_i),
    .busy_o (loss_busy)
  );

  drv_abort_merge u_merge (
    .src_i         (src),
    .loss_busy_i   (loss_busy),
    .spin_ok_i     (spin_ok_i),
    .up_to_speed_i (up_to_speed_i),
    .abort_o       (abort),
    .start_ok_o    (start_ok)
  );

  drv_ready_chain #(.DELAY_STAGES(DELAY_STAGES)) u_chain (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .index_i     (index_i),
    .start_ok_i  (start_ok),
    .abort_i     (abort),
    .armed_o     (armed),
    .ready_o     (ready_o),
    .load_head_o (load_head_o)
  );

  assign rtz_no = ~armed;
endmodule

// File: rtl/drive_ready_seq_chk.sv
module drive_ready_seq_chk #(
  parameter int unsigned LOSS_CYCLES = 250000
) (
  input logic clk_i,
  input logic rst_ni,
  input logic index_i,
  input logic spin_ok_i,
  input logic up_to_speed_i,
  input logic run_i,
  input logic rtz_cmd_i,
  input logic retract_req_i,
  input logic pwr_loss_i,
  input logic speed_loss_i,
  input logic rtz_no,
  input logic load_head_o,
  input logic ready_o
);
  localparam int unsigned CW = $clog2(LOSS_CYCLES + 1);
  logic [CW-1:0] win_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          win_q <= '0;
    else if (pwr_loss_i)  win_q <= CW'(LOSS_CYCLES);
    else if (win_q != '0) win_q <= win_q - 1'b1;
  end

  always @(posedge clk_i) begin
    if (!rst_ni) p_reset_safe_r1: assert (rtz_no && !ready_o && !load_head_o);
  end

  p_arm_on_index_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rtz_no) |-> $past(index_i && spin_ok_i && up_to_speed_i));

  p_pulse_with_ready_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_o) |-> load_head_o);

  p_pulse_on_index_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_head_o |-> (ready_o && $past(index_i)));

  p_single_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_head_o |=> !load_head_o);

  p_abort_retracts_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rtz_cmd_i || retract_req_i || pwr_loss_i || speed_loss_i || !run_i)
      |=> (rtz_no && !ready_o));

  p_ready_armed_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> !rtz_no);

  p_loss_window_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_q != '0) |-> rtz_no);
endmodule

bind drive_ready_seq drive_ready_seq_chk #(.LOSS_CYCLES(LOSS_CYCLES)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .index_i       (index_i),
  .spin_ok_i     (spin_ok_i),
  .up_to_speed_i (up_to_speed_i),
  .run_i         (run_i),
  .rtz_cmd_i     (rtz_cmd_i),
  .retract_req_i (retract_req_i),
  .pwr_loss_i    (pwr_loss_i),
  .speed_loss_i  (speed_loss_i),
  .rtz_no        (rtz_no),
  .load_head_o   (load_head_o),
  .ready_o       (ready_o)
);

// File: tb/drive_ready_seq_tb.sv
module drive_ready_seq_tb;
  localparam int unsigned LC = 8;
  localparam int NV = 20;
  // stimulus {idx,spin,up,run,cmd,retr,loss,flt}, expected {rtz_n,ready,lh}, req
  localparam logic [7:0] IDLE = 8'b0111_0000;
  localparam logic [14:0] VEC [NV] = '{
    {8'b0111_0000, 3'b100, 4'd1},  // R1 idle after reset
    {8'b1011_0000, 3'b100, 4'd9},  // R9 no spin
    {8'b1101_0000, 3'b100, 4'd9},  // R9 not up to speed
    {8'b1111_0000, 3'b000, 4'd2},  // R2 arm
    {8'b0111_0000, 3'b000, 4'd2},
    {8'b1111_0000, 3'b000, 4'd3},  // R3 second stage
    {8'b1111_0000, 3'b011, 4'd3},  // R3 load head + ready
    {8'b0111_0000, 3'b010, 4'd4},  // R4
    {8'b1111_0000, 3'b010, 4'd4},  // R4 no second pulse
    {8'b0111_1000, 3'b100, 4'd5},  // R5 return-zero command
    {8'b1111_0000, 3'b000, 4'd6},  // R6 restart
    {8'b1111_0000, 3'b000, 4'd6},
    {8'b1111_0000, 3'b011, 4'd6},
    {8'b0111_0100, 3'b100, 4'd5},  // R5 retract request
    {8'b1111_0001, 3'b100, 4'd8},  // R8 fault with index
    {8'b1111_0000, 3'b000, 4'd2},
    {8'b1110_0000, 3'b100, 4'd8},  // R8 load switch with index
    {8'b1111_0000, 3'b000, 4'd2},
    {8'b0111_0001, 3'b100, 4'd5},  // R5 speed loss
    {8'b1111_0000, 3'b000, 4'd2}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic idx, spin, up, run, cmd, retr, loss, flt;
  logic rtz_n, lh, rdy;
  int errors = 0, checks = 0;

  always #4 clk = ~clk;

  drive_ready_seq #(.DELAY_STAGES(2), .LOSS_CYCLES(LC)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .index_i(idx), .spin_ok_i(spin),
    .up_to_speed_i(up), .run_i(run), .rtz_cmd_i(cmd), .retract_req_i(retr),
    .pwr_loss_i(loss), .speed_loss_i(flt),
    .rtz_no(rtz_n), .load_head_o(lh), .ready_o(rdy)
  );

  task automatic drive(logic [7:0] v);
    {idx, spin, up, run, cmd, retr, loss, flt} = v;
  endtask

  task automatic step(logic [7:0] v);
    drive(v);
    @(negedge clk);
    drive(IDLE);
  endtask

  task automatic check(string req, logic [2:0] exp);
    checks++;
    if ({rtz_n, rdy, lh} !== exp) begin
      errors++;
      $display("FAIL %s: {rtz_n,ready,lh} actual=%b expected=%b", req, {rtz_n, rdy, lh}, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    finish_run();
  end

  initial begin
    drive(IDLE);
    repeat (3) @(negedge clk);
    check("R1", 3'b100);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", 3'b100);

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][14:7]);
      check($sformatf("R%0d vec%0d", VEC[i][3:0], i), VEC[i][6:4]);
    end

    // bring to ready, then power loss with a repeat inside the window (R7)
    step(8'b1111_0000); step(8'b1111_0000);
    check("R3", 3'b011);
    step(8'b0111_0010);
    check("R7 loss retracts", 3'b100);
    repeat (3) @(negedge clk);
    step(8'b0111_0010);  // repeat loss reloads the timer
    repeat (LC - 1) @(negedge clk);
    step(8'b1111_0000);  // last busy edge
    check("R7 index in window ignored", 3'b100);
    step(8'b1111_0000);
    check("R7 rearm after window", 3'b000);
    step(8'b1111_0000); step(8'b1111_0000);
    check("R7 ready after recovery", 3'b011);

    // asynchronous reset while ready (R1)
    #2 rst_n = 1'b0;
    #1 check("R1 async reset", 3'b100);
    @(negedge clk);
    rst_n = 1'b1;
    step(8'b1111_0000);
    check("R2 arm after reset", 3'b000);

    finish_run();
  end
endmodule